// File: doc/BRIEF.md
# Absolute Position Encoder Slave Emulator

This block plays the encoder side of a unidirectional, clocked serial position link. A master requests a reading by toggling its clock line; the emulator answers on a single data line. It is meant as a synthesizable partner for testing a master, or to stand in for a real encoder. The position, error and warning values come from input ports and are latched once per request. The master clock is brought into the system clock domain through a synchroniser, and every decision is taken on its detected edges.

While ready, the data line sits high. The first falling edge of the master clock starts a cycle. On the second rising edge the emulator latches its inputs and pulls the data line low. This is the acknowledge phase, which models the conversion delay. The acknowledge ends only on a rising master edge, so at slow master rates it lasts longer than the programmed delay. After that, one frame bit appears per rising edge.

When the frame is done, or when the master abandons it by parking its clock high, the data line is held low. It goes high again only after a minimum request period, counted from the start of the cycle. The minimum period, the conversion delay and the abandon detection time are all parameters counted in system clocks.

Top module: `enc_slave_emu`

## Requirements
- R1: After reset, and whenever the emulator is ready for a new request, `sdo_o` is 1.
- R2: A falling edge on `sclk_i` while ready starts a cycle. `sdo_o` becomes 0 after the second rising edge of `sclk_i` in that cycle, and `pos_i`, `err_n_i` and `warn_n_i` are latched at that edge.
- R3: The acknowledge phase ends only on a rising edge that is detected at least `ACK_CYC` system clocks after the detection of the second rising edge. Until that edge `sdo_o` stays 0.
- R4: Starting at the rising edge that ends the acknowledge, each rising edge presents one bit in this order: 1, 0, the latched position MSB first, error, warning, then the 6-bit check value bitwise inverted, MSB first. The check value uses polynomial x^6 + x + 1 with initial value 0. It covers position (MSB first), then error, then warning.
- R5: Changes on `pos_i`, `err_n_i` and `warn_n_i` after the latch point have no effect on the frame being sent.
- R6: The rising edge after the last check bit sets `sdo_o` to 0. `sdo_o` returns to 1 on the first system clock at which at least `CYCLE_MIN_CYC` clocks have passed since the cycle-start edge was detected and `sclk_i` is high.
- R7: If `sclk_i` stays high for `LINE_IDLE_CYC` system clocks before the frame is complete, the frame is abandoned. `sdo_o` goes to 0 and the R6 rule for returning to 1 applies.
- R8: Edges on `sclk_i` while `sdo_o` is held low after a frame are ignored and do not start a new cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Master clock line, asynchronous to `clk` |
| pos_i | input | POS_W | Position value to report |
| err_n_i | input | 1 | Error flag, active low, sent as is |
| warn_n_i | input | 1 | Warning flag, active low, sent as is |
| sdo_o | output | 1 | Data line to the master |

## Verification
The hardest behaviour to reach is the interplay between how a cycle ends and the minimum period. A frame can end by the extra rising edge or by the master parking its clock, and it can finish before or after the minimum period expires. The bench varies the master half period between 4 and 30 system clocks. This produces both short frames that must wait out the period and slow frames that run past it. It abandons a quarter of the frames at a randomly chosen edge, and sends a stray clock burst during the hold phase. For every cycle the bench predicts the exact system clock on which the line returns high.

// File: rtl/enc_slave_pkg.sv
package enc_slave_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WAIT1 = 3'd1,
        ST_WAIT2 = 3'd2,
        ST_ACK   = 3'd3,
        ST_SHIFT = 3'd4,
        ST_HOLD  = 3'd5
    } slv_state_e;

    // One serial step of the x^6 + x + 1 check value, data bit fed at the top.
    function automatic logic [5:0] crc6_step(input logic [5:0] c, input logic b);
        logic fb;
        fb = b ^ c[5];
        return {c[4:0], 1'b0} ^ {4'b0000, fb, fb};
    endfunction

endpackage

// File: rtl/enc_line_sync.sv
module enc_line_sync #(
    parameter int STAGES     = 2,
    parameter int IDLE_LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o,
    output logic idle_o
);
    localparam int CW = $clog2(IDLE_LIMIT + 1);

    // sh_q[STAGES-1] is the synchronised level, sh_q[STAGES] its previous value
    logic [STAGES:0] sh_q;

    for (genvar g = 0; g <= STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q[g] <= 1'b1;
                else        sh_q[g] <= line_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q[g] <= 1'b1;
                else        sh_q[g] <= sh_q[g-1];
            end
        end
    end

    assign lvl_o  = sh_q[STAGES-1];
    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];

    logic [CW-1:0] hi_cnt_d, hi_cnt_q;

    always_comb begin
        hi_cnt_d = hi_cnt_q;
        if (!lvl_o)                          hi_cnt_d = '0;
        else if (hi_cnt_q < CW'(IDLE_LIMIT)) hi_cnt_d = hi_cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_cnt_q <= '0;
        else        hi_cnt_q <= hi_cnt_d;
    end

    assign idle_o = (hi_cnt_q >= CW'(IDLE_LIMIT));

    // R7: the idle count only accumulates while the level stays high
    p_idle_needs_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_o) |=> (hi_cnt_q == '0));

endmodule

// File: rtl/enc_frame_build.sv
module enc_frame_build
    import enc_slave_pkg::*;
#(
    parameter int POS_W = 12
) (
    input  logic [POS_W-1:0]  pos_i,
    input  logic              err_n_i,
    input  logic              warn_n_i,
    output logic [POS_W+9:0]  frame_o
);
    localparam int DW = POS_W + 2;

    logic [DW-1:0] payload;
    logic [5:0]    chk;

    assign payload = {pos_i, err_n_i, warn_n_i};

    always_comb begin
        chk = 6'd0;
        for (int i = DW - 1; i >= 0; i--) begin
            chk = crc6_step(chk, payload[i]);
        end
    end

    assign frame_o = {1'b1, 1'b0, payload, ~chk};

endmodule

// File: rtl/enc_slave_emu.sv
module enc_slave_emu
    import enc_slave_pkg::*;
#(
    parameter int POS_W         = 12,
    parameter int ACK_CYC       = 40,
    parameter int CYCLE_MIN_CYC = 1200,
    parameter int LINE_IDLE_CYC = 64,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic             err_n_i,
    input  logic             warn_n_i,
    output logic             sdo_o
);
    localparam int FW    = POS_W + 10;
    localparam int IDX_W = $clog2(FW);
    localparam int ACK_W = $clog2(ACK_CYC + 1);
    localparam int CYC_W = $clog2(CYCLE_MIN_CYC + 1);

    typedef struct packed {
        slv_state_e       state;
        logic [FW-1:0]    frame;
        logic [IDX_W-1:0] idx;
        logic [ACK_W-1:0] ack_cnt;
        logic [CYC_W-1:0] cyc_cnt;
        logic             sdo;
    } regs_t;

    logic lvl, rise, fall, idle_hit;
    logic [FW-1:0] built;
    regs_t r_d, r_q;

    enc_line_sync #(
        .STAGES     (SYNC_STAGES),
        .IDLE_LIMIT (LINE_IDLE_CYC)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (sclk_i),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall),
        .idle_o (idle_hit)
    );

    enc_frame_build #(.POS_W(POS_W)) u_build (
        .pos_i    (pos_i),
        .err_n_i  (err_n_i),
        .warn_n_i (warn_n_i),
        .frame_o  (built)
    );

    always_comb begin
        r_d = r_q;
        if (r_q.state != ST_IDLE && r_q.cyc_cnt < CYC_W'(CYCLE_MIN_CYC))
            r_d.cyc_cnt = r_q.cyc_cnt + 1'b1;

        case (r_q.state)
            ST_IDLE: begin
                if (fall) begin
                    r_d.state   = ST_WAIT1;
                    r_d.cyc_cnt = CYC_W'(1);
                end
            end
            ST_WAIT1: begin
                if (idle_hit)  r_d.state = ST_HOLD;
                else if (rise) r_d.state = ST_WAIT2;
            end
            ST_WAIT2: begin
                if (idle_hit) begin
                    r_d.state = ST_HOLD;
                end else if (rise) begin
                    r_d.state   = ST_ACK;
                    r_d.frame   = built;
                    r_d.ack_cnt = ACK_W'(1);
                    r_d.idx     = '0;
                end
            end
            ST_ACK: begin
                if (r_q.ack_cnt < ACK_W'(ACK_CYC))
                    r_d.ack_cnt = r_q.ack_cnt + 1'b1;
                if (idle_hit)
                    r_d.state = ST_HOLD;
                else if (rise && r_q.ack_cnt >= ACK_W'(ACK_CYC))
                    r_d.state = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (idle_hit) begin
                    r_d.state = ST_HOLD;
                end else if (rise) begin
                    if (r_q.idx == IDX_W'(FW - 1)) begin
                        r_d.state = ST_HOLD;
                    end else begin
                        r_d.frame = {r_q.frame[FW-2:0], 1'b0};
                        r_d.idx   = r_q.idx + 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (lvl && r_q.cyc_cnt >= CYC_W'(CYCLE_MIN_CYC))
                    r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_HOLD;
        endcase

        case (r_d.state)
            ST_ACK, ST_HOLD: r_d.sdo = 1'b0;
            ST_SHIFT:        r_d.sdo = r_d.frame[FW-1];
            default:         r_d.sdo = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.sdo   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign sdo_o = r_q.sdo;

    // R2: second rising edge pulls the line low
    p_low_on_second_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_WAIT2 && rise && !idle_hit) |=> !sdo_o);

    // R3: no start bit before the delay has run out and a rising edge arrives
    p_ack_holds_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ACK && (!rise || r_q.ack_cnt < ACK_W'(ACK_CYC))) |=> !sdo_o);

    // R4: the qualifying rising edge shows the start bit
    p_start_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ACK && rise && !idle_hit && r_q.ack_cnt >= ACK_W'(ACK_CYC))
        |=> sdo_o);

    // R5: the latched frame moves only on rising edges
    p_frame_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SHIFT && !rise) |=> $stable(r_q.frame));

    // R6: ready again only after the minimum period with the clock line high
    p_ready_after_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sdo_o) && $past(r_q.state) == ST_HOLD)
        |-> ($past(r_q.cyc_cnt) >= CYC_W'(CYCLE_MIN_CYC) && $past(lvl)));

    // R7: a parked clock abandons the frame
    p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_hit && (r_q.state == ST_WAIT1 || r_q.state == ST_WAIT2 ||
                      r_q.state == ST_ACK || r_q.state == ST_SHIFT))
        |=> (r_q.state == ST_HOLD && !sdo_o));

    // R8: edges during the hold phase never start a cycle
    p_hold_ignores_edges_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_HOLD) |=> (r_q.state == ST_HOLD || r_q.state == ST_IDLE));

endmodule

// File: tb/enc_slave_emu_bench.sv
module enc_slave_emu_bench;
    localparam int POS_W = 12;
    localparam int ACK   = 40;
    localparam int CM    = 1200;
    localparam int LIM   = 64;
    localparam int FW    = POS_W + 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1;
    logic [POS_W-1:0] pos = '0;
    logic err_n = 1'b1;
    logic warn_n = 1'b1;
    logic sdo;

    int cyc = 0;
    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    enc_slave_emu #(
        .POS_W(POS_W), .ACK_CYC(ACK), .CYCLE_MIN_CYC(CM), .LINE_IDLE_CYC(LIM), .SYNC_STAGES(2)
    ) u_enc_slave_emu (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .pos_i(pos),
        .err_n_i(err_n), .warn_n_i(warn_n), .sdo_o(sdo)
    );

    task automatic chk(input int got, input int exp, input string tag);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    function automatic logic [FW-1:0] expect_frame(input logic [POS_W-1:0] p,
                                                   input logic e, input logic w);
        logic [POS_W+1:0] d;
        logic [5:0] c;
        logic fb;
        d = {p, e, w};
        c = 6'd0;
        for (int i = POS_W + 1; i >= 0; i--) begin
            fb = d[i] ^ c[5];
            c = {c[4:0], 1'b0};
            if (fb) c = c ^ 6'b000011;
        end
        return {1'b1, 1'b0, d, ~c};
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic run_frame(input int h, input int abort_sel, input bit burst);
        logic [FW-1:0] fr;
        int js, total, abort_at, f, tr, r_exp, exp_bit;
        bit aborted;
        chk(int'(sdo), 1, "R1 ready before request");
        pos = POS_W'($urandom);
        err_n = 1'($urandom);
        warn_n = 1'($urandom);
        fr = expect_frame(pos, err_n, warn_n);
        js = 3;
        while ((js - 2) * 2 * h < ACK) js++;
        total = js + FW;
        abort_at = (abort_sel > 0) ? 1 + (abort_sel % (total - 1)) : 0;
        aborted = 1'b0;
        tr = 0;
        sclk = 1'b0;
        f = cyc;
        wait_clk(h);
        for (int j = 1; j <= total; j++) begin
            sclk = 1'b1;
            tr = cyc;
            wait_clk(h);
            if (j == 1) begin
                chk(int'(sdo), 1, "R2 high after first rise");
            end else if (j == 2) begin
                chk(int'(sdo), 0, "R2 low after second rise");
                pos = POS_W'($urandom);
                err_n = ~err_n;
                warn_n = 1'($urandom);
            end else if (j < js) begin
                chk(int'(sdo), 0, "R3 acknowledge still low");
            end else if (j < total) begin
                exp_bit = int'(fr[FW - 1 - (j - js)]);
                chk(int'(sdo), exp_bit, (j == js) ? "R3 start bit on edge" : "R4 R5 frame bit");
            end else begin
                exp_bit = (tr + h >= max2(f + 3 + CM, tr + 4)) ? 1 : 0;
                chk(int'(sdo), exp_bit, "R6 line after final edge");
            end
            if (j == abort_at) begin
                aborted = 1'b1;
                break;
            end
            if (j < total) begin
                sclk = 1'b0;
                wait_clk(h);
            end
        end
        if (aborted) begin
            if (tr + LIM + 6 < f + 3 + CM) begin
                wait_clk(tr + LIM + 6 - cyc);
                chk(int'(sdo), 0, "R7 abandoned frame held low");
            end
            r_exp = max2(f + 3 + CM, tr + 4 + LIM);
        end else if (burst && cyc + 60 < f + CM) begin
            for (int k = 0; k < 3; k++) begin
                sclk = 1'b0;
                wait_clk(5);
                sclk = 1'b1;
                wait_clk(5);
                chk(int'(sdo), 0, "R8 burst during hold ignored");
            end
            r_exp = f + 3 + CM;
        end else begin
            r_exp = max2(f + 3 + CM, tr + 4);
        end
        if (cyc < r_exp) begin
            while (sdo == 1'b0 && cyc < r_exp + 3000) wait_clk(1);
            chk(cyc, r_exp, aborted ? "R7 ready time after abandon" : "R6 ready time");
        end else begin
            chk(int'(sdo), 1, "R6 ready after long frame");
        end
        wait_clk(int'($urandom_range(0, 20)));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        wait_clk(4);
        chk(int'(sdo), 1, "R1 reset value");
        rst_n = 1'b1;
        wait_clk(4);
        chk(int'(sdo), 1, "R1 idle after reset");
        run_frame(10, 0, 1'b0);   // R3 delay met exactly on an edge
        run_frame(4, 0, 1'b0);    // R3 many acknowledge edges
        run_frame(30, 0, 1'b0);   // R6 frame outlasts minimum period
        run_frame(6, 0, 1'b1);    // R8 stray burst in hold
        run_frame(5, 1, 1'b0);    // R7 abandon after second rise
        run_frame(7, 18, 1'b0);   // R7 abandon mid frame
        for (int n = 0; n < 24; n++) begin
            run_frame(int'($urandom_range(4, 30)),
                      ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 200)) : 0,
                      1'($urandom));
        end
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule